// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns table read and table write requests from a small processor core into cycles on a multiplexed external address/data bus. A request brings an address, an 8-bit write latch value and a strobe. The controller then puts the address on the shared pins under an address-latch pulse. After that it drives data or collects it under read or write strobes. It adds 0 to 3 programmable wait cycles, releases the strobes, and returns a byte for reads. The core is held off by a stall output for the whole cycle.

A one-byte control register sets three things. The first is pin ownership: the bus either holds the shared pins all the time, or lets general I/O drive them except while a bus cycle is running. The second is the wait count, which uses an inverted code. The third is the 16-bit write strobe mode. In word mode, the value written to an even address is parked in a holding register and costs no bus cycle. The next odd-address write drives the full 16-bit word. A lock input marks internal-only operation and freezes the register.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the stall output is low, no read-valid pulse is present, and the bus owns the pins.
- R2: The register holds pin release in bit 7, the wait code in bits 5:4 and the write mode in bits 1:0. Bits 6, 3 and 2 always read 0, so writing 0xFF reads back 0xB3.
- R3: While the lock input is high, register writes are ignored and the readback value does not change.
- R4: The wait code W adds 3−W wait cycles: code 11 adds 0 and code 00 adds 3. A bus cycle stalls the core for 3+(3−W) cycles, and its read/write strobe stays high for 1+(3−W) cycles.
- R5: With bit 7 clear, the bus owns the pins at all times. While idle the pin output enables are all 0, whatever the general I/O drives.
- R6: With bit 7 set, the pins carry the general I/O value and enable whenever no bus cycle is running. During a cycle (stall high) the bus owns them, with all enables high in the address phase.
- R7: Word mode (mode 1x, 16-bit width): an even-address write runs no bus cycle and parks the latch byte. An odd-address write drives {latch, parked byte} and raises only the high write strobe.
- R8: Byte-select mode (mode 01, 16-bit width): the latch is copied to both bytes. The high write strobe rises with the upper-byte enable when address bit 0 is 1, or with the lower-byte enable when it is 0.
- R9: Byte-write mode (mode 00, 16-bit width): the latch is copied to both bytes. Only the high write strobe fires on an odd address, and only the low one on an even address.
- R10: With 8-bit width selected, the write mode has no effect. Every write runs a bus cycle with {0x00, latch} on the pins and only the low write strobe.
- R11: A read raises only the read strobe. In 16-bit width it returns the upper pin byte when address bit 0 is 1 and the lower byte otherwise; in 8-bit width it always returns the lower byte. The byte is sampled at the end of the last strobe cycle and returned with a one-cycle valid pulse in the final stall cycle.
- R12: Each bus cycle begins with exactly one address-latch cycle carrying the address on the pins, followed by the strobes. A request made while the stall is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_lock | input | 1 | Internal-only operation: register ignores writes |
| cfg_rdata | output | 8 | Control register readback |
| bus_wide | input | 1 | 1 = 16-bit data width, 0 = 8-bit |
| tbl_req | input | 1 | Table request strobe (taken only while not stalled) |
| tbl_wr | input | 1 | 1 = table write, 0 = table read |
| tbl_addr | input | AW | Table address |
| tbl_latch | input | BYTE_W | Write latch byte |
| tbl_stall | output | 1 | Core stall during a bus cycle |
| tbl_rdata | output | BYTE_W | Read result byte |
| tbl_rvalid | output | 1 | One-cycle read result valid |
| ale_o | output | 1 | Address latch enable |
| rd_stb_o | output | 1 | Read strobe |
| wr_hi_o | output | 1 | High write strobe |
| wr_lo_o | output | 1 | Low write strobe |
| ub_o | output | 1 | Upper byte enable |
| lb_o | output | 1 | Lower byte enable |
| gpio_o | input | 2*BYTE_W | General I/O output value for the shared pins |
| gpio_oe | input | 2*BYTE_W | General I/O output enables for the shared pins |
| pin_o | output | 2*BYTE_W | Shared pin output value |
| pin_oe | output | 2*BYTE_W | Shared pin output enables |
| pin_i | input | 2*BYTE_W | Shared pin input value |
| bus_own | output | 1 | Bus currently owns the shared pins |

## Verification
The bench uses the default build: 8-bit bytes and a 16-bit address on 16 shared pins. At this size every combination of wait code, write mode, data width, address parity and read/write fits in one short run. Each of the 128 accesses is timed cycle by cycle against the stall and strobe lengths derived from the wait code. A responder presents valid read data only in the last strobe cycle, which exposes any sampling one cycle early or late. Separate passes cover pin ownership under both settings of bit 7, the register lock and requests made during a stall.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int CFG_W    = 8;
  localparam int BIT_REL  = 7;
  localparam int WAIT_LO  = 4;
  localparam int WMODE_LO = 0;
  localparam int WAIT_W   = 2;
  localparam int WMODE_W  = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_WAIT,
    PH_REL
  } phase_e;

  typedef struct packed {
    logic               rel;
    logic [WAIT_W-1:0]  wcode;
    logic [WMODE_W-1:0] wmode;
  } cfg_t;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic ub;
    logic lb;
    logic rd;
  } stb_t;

  // Inverted code: all ones means no extra cycles.
  function automatic logic [WAIT_W-1:0] wait_cycles(input logic [WAIT_W-1:0] code);
    return ~code;
  endfunction

endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lock,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we && !lock) begin
      cfg.rel   <= wdata[BIT_REL];
      cfg.wcode <= wdata[WAIT_LO +: WAIT_W];
      cfg.wmode <= wdata[WMODE_LO +: WMODE_W];
    end
  end

  always_comb begin
    rdata                        = '0;
    rdata[BIT_REL]               = cfg.rel;
    rdata[WAIT_LO +: WAIT_W]     = cfg.wcode;
    rdata[WMODE_LO +: WMODE_W]   = cfg.wmode;
  end

endmodule

// File: rtl/xbus_lane_fmt.sv
module xbus_lane_fmt
  import xbus_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PW    = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               wr,
  input  logic               a0,
  input  logic [BYTE_W-1:0]  latch,
  input  logic               wide,
  input  logic [WMODE_W-1:0] wmode,
  output logic [PW-1:0]      word,
  output stb_t               stb,
  output logic               need_bus
);

  logic [BYTE_W-1:0] hold_q;
  logic              park;

  // Even-address write in word mode only fills the holding byte.
  assign park     = wr && wide && wmode[1] && !a0;
  assign need_bus = !park;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (take && park) begin
      hold_q <= latch;
    end
  end

  always_comb begin
    word = '0;
    stb  = '0;
    if (!wr) begin
      stb.rd = 1'b1;
    end else if (!wide) begin
      word     = {{BYTE_W{1'b0}}, latch};
      stb.wr_lo = 1'b1;
    end else if (wmode[1]) begin
      word      = {latch, hold_q};
      stb.wr_hi = 1'b1;
    end else if (wmode[0]) begin
      word      = {latch, latch};
      stb.wr_hi = 1'b1;
      stb.ub    = a0;
      stb.lb    = !a0;
    end else begin
      word      = {latch, latch};
      stb.wr_hi = a0;
      stb.wr_lo = !a0;
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int BYTE_W = 8,
  localparam int PW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [PW-1:0]     word,
  input  stb_t              stb_sel,
  input  logic              need_bus,
  input  logic              wide,
  input  logic [WAIT_W-1:0] wcode,
  input  logic [PW-1:0]     pin_i,
  output logic              take,
  output logic              stall,
  output logic              ale,
  output stb_t              stb,
  output logic [PW-1:0]     ad_o,
  output logic              ad_oe,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);

  phase_e            ph, ph_n;
  logic [WAIT_W-1:0] cnt, cnt_n;
  logic [WAIT_W-1:0] nwait_q;
  logic              wr_q, a0_q, wide_q;
  logic [PW-1:0]     word_q;
  stb_t              sel_q;
  logic [PW-1:0]     addr_pins;
  logic              start, last_stb, data_ph_n;

  generate
    if (AW >= PW) begin : g_addr_trim
      assign addr_pins = addr[PW-1:0];
    end else begin : g_addr_pad
      assign addr_pins = {{(PW-AW){1'b0}}, addr};
    end
  endgenerate

  assign take     = req && (ph == PH_IDLE);
  assign start    = take && need_bus;
  assign last_stb = ((ph == PH_DATA) && (nwait_q == '0)) ||
                    ((ph == PH_WAIT) && (cnt == '0));
  assign data_ph_n = (ph_n == PH_DATA) || (ph_n == PH_WAIT) || (ph_n == PH_REL);

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    unique case (ph)
      PH_IDLE: if (start) ph_n = PH_ADDR;
      PH_ADDR: ph_n = PH_DATA;
      PH_DATA: begin
        if (nwait_q == '0) begin
          ph_n = PH_REL;
        end else begin
          ph_n  = PH_WAIT;
          cnt_n = nwait_q - 1'b1;
        end
      end
      PH_WAIT: begin
        if (cnt == '0) ph_n = PH_REL;
        else           cnt_n = cnt - 1'b1;
      end
      PH_REL:  ph_n = PH_IDLE;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      nwait_q  <= '0;
      wr_q     <= 1'b0;
      a0_q     <= 1'b0;
      wide_q   <= 1'b0;
      word_q   <= '0;
      sel_q    <= '0;
      stall    <= 1'b0;
      ale      <= 1'b0;
      stb      <= '0;
      ad_o     <= '0;
      ad_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      ph  <= ph_n;
      cnt <= cnt_n;
      if (start) begin
        nwait_q <= wait_cycles(wcode);
        wr_q    <= wr;
        a0_q    <= addr[0];
        wide_q  <= wide;
        word_q  <= word;
        sel_q   <= stb_sel;
      end
      stall <= (ph_n != PH_IDLE);
      ale   <= (ph_n == PH_ADDR);
      stb   <= ((ph_n == PH_DATA) || (ph_n == PH_WAIT)) ? sel_q : '0;
      if (ph_n == PH_ADDR) begin
        ad_o  <= addr_pins;
        ad_oe <= 1'b1;
      end else if (wr_q && data_ph_n) begin
        ad_o  <= word_q;
        ad_oe <= 1'b1;
      end else begin
        ad_o  <= '0;
        ad_oe <= 1'b0;
      end
      rd_valid <= !wr_q && last_stb;
      if (!wr_q && last_stb) begin
        rd_data <= (wide_q && a0_q) ? pin_i[PW-1:BYTE_W] : pin_i[BYTE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/xbus_pin_share.sv
module xbus_pin_share #(
  parameter int PW = 16
) (
  input  logic          rel,
  input  logic          busy,
  input  logic [PW-1:0] ad_o,
  input  logic          ad_oe,
  input  logic [PW-1:0] gpio_o,
  input  logic [PW-1:0] gpio_oe,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe,
  output logic          own
);

  assign own    = !rel || busy;
  assign pin_o  = own ? ad_o : gpio_o;
  assign pin_oe = own ? {PW{ad_oe}} : gpio_oe;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int BYTE_W = 8,
  localparam int PW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cfg_lock,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              bus_wide,
  input  logic              tbl_req,
  input  logic              tbl_wr,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [BYTE_W-1:0] tbl_latch,
  output logic              tbl_stall,
  output logic [BYTE_W-1:0] tbl_rdata,
  output logic              tbl_rvalid,
  output logic              ale_o,
  output logic              rd_stb_o,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              ub_o,
  output logic              lb_o,
  input  logic [PW-1:0]     gpio_o,
  input  logic [PW-1:0]     gpio_oe,
  output logic [PW-1:0]     pin_o,
  output logic [PW-1:0]     pin_oe,
  input  logic [PW-1:0]     pin_i,
  output logic              bus_own
);

  cfg_t          cfg;
  stb_t          stb_sel, stb;
  logic [PW-1:0] word, ad_o;
  logic          ad_oe, need_bus, take;

  xbus_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .lock  (cfg_lock),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  xbus_lane_fmt #(.BYTE_W(BYTE_W)) u_lane (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .wr       (tbl_wr),
    .a0       (tbl_addr[0]),
    .latch    (tbl_latch),
    .wide     (bus_wide),
    .wmode    (cfg.wmode),
    .word     (word),
    .stb      (stb_sel),
    .need_bus (need_bus)
  );

  xbus_seq #(.AW(AW), .BYTE_W(BYTE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (tbl_req),
    .wr       (tbl_wr),
    .addr     (tbl_addr),
    .word     (word),
    .stb_sel  (stb_sel),
    .need_bus (need_bus),
    .wide     (bus_wide),
    .wcode    (cfg.wcode),
    .pin_i    (pin_i),
    .take     (take),
    .stall    (tbl_stall),
    .ale      (ale_o),
    .stb      (stb),
    .ad_o     (ad_o),
    .ad_oe    (ad_oe),
    .rd_data  (tbl_rdata),
    .rd_valid (tbl_rvalid)
  );

  xbus_pin_share #(.PW(PW)) u_pins (
    .rel     (cfg.rel),
    .busy    (tbl_stall),
    .ad_o    (ad_o),
    .ad_oe   (ad_oe),
    .gpio_o  (gpio_o),
    .gpio_oe (gpio_oe),
    .pin_o   (pin_o),
    .pin_oe  (pin_oe),
    .own     (bus_own)
  );

  assign rd_stb_o = stb.rd;
  assign wr_hi_o  = stb.wr_hi;
  assign wr_lo_o  = stb.wr_lo;
  assign ub_o     = stb.ub;
  assign lb_o     = stb.lb;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          cfg_lock,
  input logic [7:0]    cfg_rdata,
  input logic          tbl_stall,
  input logic          tbl_rvalid,
  input logic          ale_o,
  input logic          rd_stb_o,
  input logic          wr_hi_o,
  input logic          wr_lo_o,
  input logic          ub_o,
  input logic          lb_o,
  input logic [PW-1:0] gpio_oe,
  input logic [PW-1:0] pin_oe,
  input logic          bus_own
);

  logic any_stb;
  assign any_stb = rd_stb_o || wr_hi_o || wr_lo_o;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rdata == 8'h00 && !tbl_stall && !tbl_rvalid));

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_lock && cfg_we) |=> $stable(cfg_rdata));

  assert_bus_pinned_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[7] |-> bus_own);

  assert_gpio_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[7] && !tbl_stall) |-> (pin_oe == gpio_oe));

  assert_byte_enable_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ub_o, lb_o}));

  assert_one_write_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_hi_o && wr_lo_o));

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    tbl_rvalid |=> !tbl_rvalid);

  assert_strobe_in_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> (tbl_stall && !ale_o));

  assert_ale_then_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> (any_stb && !ale_o));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.PW(PW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_lock   (cfg_lock),
  .cfg_rdata  (cfg_rdata),
  .tbl_stall  (tbl_stall),
  .tbl_rvalid (tbl_rvalid),
  .ale_o      (ale_o),
  .rd_stb_o   (rd_stb_o),
  .wr_hi_o    (wr_hi_o),
  .wr_lo_o    (wr_lo_o),
  .ub_o       (ub_o),
  .lb_o       (lb_o),
  .gpio_oe    (gpio_oe),
  .pin_oe     (pin_oe),
  .bus_own    (bus_own)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int AW    = 16;
  localparam int BW    = 8;
  localparam int PW    = 2 * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0, cfg_lock = 1'b0;
  logic [7:0]    cfg_wdata = '0, cfg_rdata;
  logic          bus_wide = 1'b1;
  logic          tbl_req = 1'b0, tbl_wr = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [BW-1:0] tbl_latch = '0, tbl_rdata;
  logic          tbl_stall, tbl_rvalid;
  logic          ale_o, rd_stb_o, wr_hi_o, wr_lo_o, ub_o, lb_o;
  logic [PW-1:0] gpio_o = '0, gpio_oe = '0, pin_o, pin_oe;
  logic [PW-1:0] pin_i = '0;
  logic          bus_own;

  int n_total = 0;
  int n_fail  = 0;

  // per-access observations
  int            o_nst, o_nstb, o_nvld, o_vk, stbk;
  logic [4:0]    o_stb;
  logic [PW-1:0] o_data, o_addr, o_oe1;
  logic [BW-1:0] o_rdata;
  logic          o_ale1, o_own1, o_extra, o_own_after;

  always #(CLK_P/2) clk = ~clk;

  xbus_ctrl #(.AW(AW), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_lock(cfg_lock), .cfg_rdata(cfg_rdata), .bus_wide(bus_wide),
    .tbl_req(tbl_req), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
    .tbl_latch(tbl_latch), .tbl_stall(tbl_stall), .tbl_rdata(tbl_rdata),
    .tbl_rvalid(tbl_rvalid), .ale_o(ale_o), .rd_stb_o(rd_stb_o),
    .wr_hi_o(wr_hi_o), .wr_lo_o(wr_lo_o), .ub_o(ub_o), .lb_o(lb_o),
    .gpio_o(gpio_o), .gpio_oe(gpio_oe), .pin_o(pin_o), .pin_oe(pin_oe),
    .pin_i(pin_i), .bus_own(bus_own)
  );

  function automatic logic [PW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] ^ 8'hC3};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Issue one request at a negedge and watch it until the stall falls.
  task automatic run_op(input logic wr, input logic [AW-1:0] addr,
                        input logic [BW-1:0] latch, input int n, input logic inject);
    tbl_req = 1'b1; tbl_wr = wr; tbl_addr = addr; tbl_latch = latch;
    @(negedge clk);
    tbl_req = 1'b0;
    o_nst = 0; o_nstb = 0; o_nvld = 0; o_vk = 0; stbk = 0;
    o_stb = '0; o_data = '0; o_rdata = '0;
    for (int k = 1; k < 40; k++) begin
      if (k == 1) begin
        o_ale1 = ale_o; o_addr = pin_o; o_own1 = bus_own; o_oe1 = pin_oe;
      end
      if (tbl_stall) o_nst++;
      if (rd_stb_o || wr_hi_o || wr_lo_o) begin
        if (o_nstb == 0) o_data = pin_o;
        o_nstb++;
        o_stb = o_stb | {wr_hi_o, wr_lo_o, ub_o, lb_o, rd_stb_o};
      end
      if (rd_stb_o) stbk++;
      pin_i = (rd_stb_o && stbk == n + 1) ? mem_word(addr) : 16'hDEAD;
      if (tbl_rvalid) begin
        o_nvld++; o_vk = k; o_rdata = tbl_rdata;
      end
      if (inject && k == 2) begin tbl_req = 1'b1; tbl_addr = addr ^ 16'h0001; end
      if (inject && k == 3) tbl_req = 1'b0;
      if (!tbl_stall) break;
      @(negedge clk);
    end
    o_own_after = bus_own;
    @(negedge clk);
    o_extra = tbl_stall;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin : main
    logic [BW-1:0] hold_m;
    hold_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(cfg_rdata == 8'h00, "R1", "cfg after reset", cfg_rdata, 0);
    check(!tbl_stall && !tbl_rvalid, "R1", "stall/valid after reset", {tbl_stall, tbl_rvalid}, 0);
    check(bus_own, "R1", "bus owns after reset", bus_own, 1);

    // R2 layout and unimplemented bits
    cfg_write(8'hFF);
    check(cfg_rdata == 8'hB3, "R2", "write FF readback", cfg_rdata, 8'hB3);
    cfg_write(8'h4C);
    check(cfg_rdata == 8'h00, "R2", "unimplemented bits only", cfg_rdata, 0);

    // R3 lock
    cfg_write(8'h21);
    cfg_lock = 1'b1;
    cfg_write(8'h92);
    check(cfg_rdata == 8'h21, "R3", "locked write ignored", cfg_rdata, 8'h21);
    cfg_lock = 1'b0;

    // R5 bus pinned while idle
    cfg_write(8'h30);
    gpio_o = 16'h1234; gpio_oe = 16'hFFFF;
    @(negedge clk);
    check(pin_oe == 16'h0000 && bus_own, "R5", "idle pins with bus pinned", pin_oe, 0);
    run_op(1'b0, 16'h0040, 8'h00, 0, 1'b0);
    check(o_own_after, "R5", "bus still owns after access", o_own_after, 1);

    // R6 shared pins
    cfg_write(8'hB0);
    @(negedge clk);
    check(!bus_own && pin_o == 16'h1234 && pin_oe == 16'hFFFF, "R6", "idle pins to gpio", pin_o, 16'h1234);
    gpio_oe = 16'h0F0F;
    @(negedge clk);
    check(pin_oe == 16'h0F0F, "R6", "gpio enables pass", pin_oe, 16'h0F0F);
    run_op(1'b0, 16'h0042, 8'h00, 0, 1'b0);
    check(o_own1 && o_oe1 == 16'hFFFF, "R6", "bus owns during access", o_oe1, 16'hFFFF);
    check(!o_own_after && pin_oe == 16'h0F0F, "R6", "pins returned after access", pin_oe, 16'h0F0F);
    gpio_oe = '0;

    // R12 request during stall ignored
    cfg_write(8'h00);
    run_op(1'b0, 16'h0100, 8'h00, 3, 1'b1);
    check(o_nst == 6, "R12", "stall with injected request", o_nst, 6);
    check(!o_extra, "R12", "no second cycle", o_extra, 0);

    // Sweep: wait code x write mode x width x address parity x direction
    for (int wc = 0; wc < 4; wc++) begin
      for (int wm = 0; wm < 4; wm++) begin
        for (int wd = 0; wd < 2; wd++) begin
          cfg_write({2'b00, wc[1:0], 2'b00, wm[1:0]});
          bus_wide = wd[0];
          for (int a0 = 0; a0 < 2; a0++) begin
            for (int w = 0; w < 2; w++) begin
              logic [AW-1:0] addr;
              logic [BW-1:0] lat;
              logic          park;
              int            n;
              logic [4:0]    e_stb;
              logic [PW-1:0] e_data;
              logic [BW-1:0] e_rd;
              string         tag;
              addr = {4'hA, wc[1:0], wm[1:0], wd[0], 6'h15, a0[0]};
              lat  = {wc[1:0], wm[1:0], wd[0], a0[0], w[0], 1'b1};
              n    = 3 - wc;
              park = w[0] && wd[0] && wm[1] && !a0[0];
              if (!w[0])      tag = "R11";
              else if (!wd[0]) tag = "R10";
              else if (wm[1]) tag = "R7";
              else if (wm[0]) tag = "R8";
              else            tag = "R9";
              if (!w[0])       e_stb = 5'b00001;
              else if (!wd[0]) e_stb = 5'b01000;
              else if (wm[1])  e_stb = 5'b10000;
              else if (wm[0])  e_stb = {1'b1, 1'b0, a0[0], !a0[0], 1'b0};
              else             e_stb = {a0[0], !a0[0], 3'b000};
              if (!wd[0])      e_data = {8'h00, lat};
              else if (wm[1])  e_data = {lat, hold_m};
              else             e_data = {lat, lat};
              e_rd = (wd[0] && a0[0]) ? mem_word(addr)[15:8] : mem_word(addr)[7:0];
              run_op(w[0], addr, lat, n, 1'b0);
              if (park) begin
                // R7 even word write parks the byte, no bus cycle
                check(o_nst == 0 && o_nstb == 0, "R7", "even word write runs no cycle", o_nst, 0);
                hold_m = lat;
              end else begin
                check(o_nst == n + 3, "R4", "stall cycles", o_nst, n + 3);
                check(o_nstb == n + 1, "R4", "strobe cycles", o_nstb, n + 1);
                check(o_ale1 && o_addr == addr, "R12", "address phase", o_addr, addr);
                check(o_stb == e_stb, tag, "strobe set", o_stb, e_stb);
                check(!o_extra, "R12", "idle after cycle", o_extra, 0);
                if (w[0]) begin
                  check(o_data == e_data, tag, "write data on pins", o_data, e_data);
                end else begin
                  check(o_nvld == 1 && o_vk == n + 3, "R11", "valid pulse timing", o_vk, n + 3);
                  check(o_rdata == e_rd, "R11", "read byte", o_rdata, e_rd);
                end
              end
            end
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule